// File: doc/BRIEF.md
# Nibble-Decoded Register Address Unit

This unit holds a file of sixteen 16-bit general registers, an 8-bit accumulator D, and two 4-bit selectors. Selector P names the register used as the program counter. Selector X names the register used as the data pointer. An instruction fetcher outside the unit hands it one opcode per strobe. The upper nibble of the opcode picks the operation, and the lower nibble N names the register to work on.

Every memory access takes its address from a register, either RN or the register named by X. Some accesses then step that register up or down by one. The unit drives the memory address, a read strobe, a write strobe and write data in the same cycle as the opcode strobe. It samples the memory read data at the clock edge that closes that cycle. For input and output operations it also drives three device-select lines. Register, accumulator and selector updates take effect at that same edge. A `done` pulse in the next cycle marks them as visible.

Top module: `regaddr_unit`

## Requirements
- R1: While reset is asserted, and right after it is released, every register, D, P and X read as zero, `done` is low, and no strobe or select line is active.
- R2: Opcode 1N adds one to RN modulo 2^16, so FFFF becomes 0000. Opcode 2N subtracts one modulo 2^16, so 0000 becomes FFFF. No memory strobe is raised.
- R3: Opcode 0N with N from 1 to F reads memory at address RN into D. Opcode 00 raises no strobe and changes no state.
- R4: Opcode 4N reads memory at address RN into D and then adds one to RN.
- R5: Opcode 5N writes D to memory at address RN and changes no register.
- R6: Opcode 8N copies bits 7:0 of RN into D, and 9N copies bits 15:8 into D. Opcode AN writes D into bits 7:0 of RN, and BN writes D into bits 15:8, leaving the other byte unchanged.
- R7: Opcode DN sets P to N, and EN sets X to N. P and X change on no other opcode. Their values are visible on `p_sel` and `x_sel`.
- R8: Opcode F0 reads memory at RX into D. Opcode 72 does the same and then adds one to RX. Opcode 73 writes D to memory at RX and then subtracts one from RX.
- R9: Opcodes 61 to 67 read memory at RX, drive `io_sel` with N bits 2:0, and add one to RX. D is unchanged.
- R10: Opcode 60 adds one to RX. It raises no strobe and leaves `io_sel` at zero.
- R11: Opcodes 69 to 6F load `io_in` into D, write `io_in` to memory at RX, and drive `io_sel` with N bits 2:0. RX is unchanged. Opcode 68 has no effect.
- R12: Strobes and `io_sel` are active only in a cycle where `op_valid` is high. `done` is high in exactly the cycle after each accepted opcode, and all of that opcode's updates are visible in that cycle.
- R13: All opcodes not listed above (3x, 7x other than 72 and 73, Cx, Fx other than F0) raise no strobe and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Opcode strobe, one cycle per opcode |
| op_code | input | 8 | Opcode: bits 7:4 operation, bits 3:0 register number N |
| mem_rdata | input | 8 | Memory read data, sampled at the end of a read cycle |
| io_in | input | 8 | Device input byte for input opcodes |
| mem_addr | output | 16 | Memory address, the content of RN or RX |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| io_sel | output | 3 | Device select lines, zero when idle |
| d_out | output | 8 | Accumulator D |
| p_sel | output | 4 | Program-counter register selector |
| x_sel | output | 4 | Data-pointer register selector |
| done | output | 1 | Pulse one cycle after an accepted opcode |

## Verification
The embedded properties watch these rules on every cycle:
- a read and a write strobe are never raised together;
- device selects appear only with a memory access;
- strobes stay quiet without an opcode;
- D, P and X stay put when no opcode asks for a change;
- incrementing FFFF or decrementing 0000 wraps correctly.

Only the bench's scenarios can show the rest:
- the right register was picked through X or N;
- the post-increment or post-decrement is applied after the access, not before;
- a byte transfer leaves the other half of the register alone;
- the idle and undefined opcodes leave every register untouched.

The bench reads every register back through the byte-copy opcodes to confirm these.

// File: rtl/rau_pkg.sv
package rau_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 4;
  localparam int IOS_W  = 3;
  localparam int OP_W   = 8;

  typedef enum logic [2:0] {
    UPD_NONE, UPD_INC, UPD_DEC, UPD_LO, UPD_HI
  } upd_e;

  typedef enum logic [2:0] {
    DSRC_KEEP, DSRC_MEM, DSRC_IO, DSRC_LO, DSRC_HI
  } dsrc_e;

  typedef struct packed {
    logic  use_x;
    upd_e  upd;
    dsrc_e dsrc;
    logic  rd;
    logic  wr;
    logic  wsrc_io;
    logic  io_en;
    logic  set_p;
    logic  set_x;
  } ctl_t;
endpackage

// File: rtl/rau_decode.sv
module rau_decode
  import rau_pkg::*;
#(
  parameter int OPW = OP_W
) (
  input  logic           valid,
  input  logic [OPW-1:0] op,
  output ctl_t           ctl
);
  localparam int NW = OPW / 2;

  logic [NW-1:0] grp;
  logic [NW-1:0] n;

  assign grp = op[OPW-1:NW];
  assign n   = op[NW-1:0];

  always_comb begin
    ctl = '0;
    if (valid) begin
      unique case (grp)
        4'h0: if (n != '0) begin
          ctl.rd   = 1'b1;
          ctl.dsrc = DSRC_MEM;
        end
        4'h1: ctl.upd = UPD_INC;
        4'h2: ctl.upd = UPD_DEC;
        4'h4: begin
          ctl.rd   = 1'b1;
          ctl.dsrc = DSRC_MEM;
          ctl.upd  = UPD_INC;
        end
        4'h5: ctl.wr = 1'b1;
        4'h6: begin
          ctl.use_x = 1'b1;
          if (n == '0) begin
            ctl.upd = UPD_INC;
          end else if (n < 4'd8) begin
            ctl.rd    = 1'b1;
            ctl.io_en = 1'b1;
            ctl.upd   = UPD_INC;
          end else if (n != 4'd8) begin
            ctl.wr      = 1'b1;
            ctl.wsrc_io = 1'b1;
            ctl.io_en   = 1'b1;
            ctl.dsrc    = DSRC_IO;
          end
        end
        4'h7: begin
          if (n == 4'd2) begin
            ctl.use_x = 1'b1;
            ctl.rd    = 1'b1;
            ctl.dsrc  = DSRC_MEM;
            ctl.upd   = UPD_INC;
          end else if (n == 4'd3) begin
            ctl.use_x = 1'b1;
            ctl.wr    = 1'b1;
            ctl.upd   = UPD_DEC;
          end
        end
        4'h8: ctl.dsrc  = DSRC_LO;
        4'h9: ctl.dsrc  = DSRC_HI;
        4'hA: ctl.upd   = UPD_LO;
        4'hB: ctl.upd   = UPD_HI;
        4'hD: ctl.set_p = 1'b1;
        4'hE: ctl.set_x = 1'b1;
        4'hF: if (n == '0) begin
          ctl.use_x = 1'b1;
          ctl.rd    = 1'b1;
          ctl.dsrc  = DSRC_MEM;
        end
        default: ctl = '0;
      endcase
    end
  end
endmodule

// File: rtl/rau_selectors.sv
module rau_selectors #(
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_p,
  input  logic          set_x,
  input  logic [SW-1:0] n,
  output logic [SW-1:0] p_q,
  output logic [SW-1:0] x_q
);
  logic [SW-1:0] p_d;
  logic [SW-1:0] x_d;

  always_comb begin
    p_d = p_q;
    x_d = x_q;
    if (set_p) p_d = n;
    if (set_x) x_d = n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q <= '0;
      x_q <= '0;
    end else begin
      if (set_p) p_q <= p_d;
      if (set_x) x_q <= x_d;
    end
  end

  assert_p_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !set_p |=> $stable(p_q));
  assert_x_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !set_x |=> $stable(x_q));
endmodule

// File: rtl/rau_regfile.sv
module rau_regfile
  import rau_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] idx,
  input  upd_e          upd,
  input  logic [BW-1:0] d,
  output logic [2*BW-1:0] rd_val
);
  localparam int RW = 2 * BW;
  localparam int NR = 1 << SW;

  logic [NR-1:0][RW-1:0] rf_all;

  for (genvar i = 0; i < NR; i++) begin : g_reg
    logic [RW-1:0] q;
    logic [RW-1:0] nxt;
    logic          en;

    assign en = (idx == SW'(i)) && (upd != UPD_NONE);

    always_comb begin
      nxt = q;
      unique case (upd)
        UPD_INC: nxt = q + RW'(1);
        UPD_DEC: nxt = q - RW'(1);
        UPD_LO:  nxt = {q[RW-1:BW], d};
        UPD_HI:  nxt = {d, q[BW-1:0]};
        default: nxt = q;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= nxt;
    end

    assign rf_all[i] = q;
  end

  assign rd_val = rf_all[idx];

  assert_inc_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd == UPD_INC && rd_val == '1) |=> (rf_all[$past(idx)] == '0));
  assert_dec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd == UPD_DEC && rd_val == '0) |=> (rf_all[$past(idx)] == '1));
endmodule

// File: rtl/regaddr_unit.sv
module regaddr_unit
  import rau_pkg::*;
#(
  parameter int BW  = BYTE_W,
  parameter int SW  = SEL_W,
  parameter int IOW = IOS_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [2*SW-1:0] op_code,
  input  logic [BW-1:0]   mem_rdata,
  input  logic [BW-1:0]   io_in,
  output logic [2*BW-1:0] mem_addr,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [BW-1:0]   mem_wdata,
  output logic [IOW-1:0]  io_sel,
  output logic [BW-1:0]   d_out,
  output logic [SW-1:0]   p_sel,
  output logic [SW-1:0]   x_sel,
  output logic            done
);
  localparam int RW = 2 * BW;

  logic [1:0]    rst_sync;
  logic          rst_i_n;
  ctl_t          ctl;
  logic [SW-1:0] n;
  logic [SW-1:0] idx;
  logic [RW-1:0] rsel;
  logic [BW-1:0] d_q;
  logic [BW-1:0] d_d;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  assign n = op_code[SW-1:0];

  rau_decode #(.OPW(2*SW)) i_dec (
    .valid (op_valid),
    .op    (op_code),
    .ctl   (ctl)
  );

  rau_selectors #(.SW(SW)) i_sel (
    .clk   (clk),
    .rst_n (rst_i_n),
    .set_p (ctl.set_p),
    .set_x (ctl.set_x),
    .n     (n),
    .p_q   (p_sel),
    .x_q   (x_sel)
  );

  assign idx = ctl.use_x ? x_sel : n;

  rau_regfile #(.BW(BW), .SW(SW)) i_rf (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .idx    (idx),
    .upd    (ctl.upd),
    .d      (d_q),
    .rd_val (rsel)
  );

  assign mem_addr  = rsel;
  assign mem_rd    = ctl.rd;
  assign mem_wr    = ctl.wr;
  assign mem_wdata = ctl.wsrc_io ? io_in : d_q;
  assign io_sel    = ctl.io_en ? n[IOW-1:0] : '0;

  always_comb begin
    unique case (ctl.dsrc)
      DSRC_MEM: d_d = mem_rdata;
      DSRC_IO:  d_d = io_in;
      DSRC_LO:  d_d = rsel[BW-1:0];
      DSRC_HI:  d_d = rsel[RW-1:BW];
      default:  d_d = d_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      d_q    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= op_valid;
      if (ctl.dsrc != DSRC_KEEP) d_q <= d_d;
    end
  end

  assign d_out = d_q;
  assign done  = done_q;

  assert_rdwr_excl_R12: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(mem_rd && mem_wr));
  assert_strobe_idle_R12: assert property (@(posedge clk) disable iff (!rst_i_n)
    !op_valid |-> (!mem_rd && !mem_wr && io_sel == '0));
  assert_iosel_access_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (io_sel != '0) |-> (mem_rd || mem_wr));
  assert_d_hold_R13: assert property (@(posedge clk) disable iff (!rst_i_n)
    !op_valid |=> $stable(d_q));
endmodule

// File: tb/test_regaddr_unit.sv
module test_regaddr_unit;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [7:0]  op_code;
  logic [7:0]  mem_rdata;
  logic [7:0]  io_in;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic        mem_wr;
  logic [7:0]  mem_wdata;
  logic [2:0]  io_sel;
  logic [7:0]  d_out;
  logic [3:0]  p_sel;
  logic [3:0]  x_sel;
  logic        done;

  logic [7:0]  mem [256];
  logic [15:0] m_r [16];
  logic [7:0]  m_d;
  logic [3:0]  m_p;
  logic [3:0]  m_x;
  int          n_chk = 0;
  int          n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:0]];

  regaddr_unit i_regaddr_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .mem_rdata(mem_rdata), .io_in(io_in), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .io_sel(io_sel), .d_out(d_out), .p_sel(p_sel), .x_sel(x_sel),
    .done(done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [7:0] op);
    case (op[7:4])
      4'h0: return "R3";
      4'h1, 4'h2: return "R2";
      4'h4: return "R4";
      4'h5: return "R5";
      4'h6: begin
        if (op[3:0] == 4'h0) return "R10";
        if (op[3:0] < 4'h8)  return "R9";
        return "R11";
      end
      4'h7: return (op[3:0] == 4'h2 || op[3:0] == 4'h3) ? "R8" : "R13";
      4'h8, 4'h9, 4'hA, 4'hB: return "R6";
      4'hD, 4'hE: return "R7";
      4'hF: return (op[3:0] == 4'h0) ? "R8" : "R13";
      default: return "R13";
    endcase
  endfunction

  task automatic do_op(input logic [7:0] op, input logic [7:0] iob);
    logic [3:0]  n = op[3:0];
    logic        e_rd = 1'b0;
    logic        e_wr = 1'b0;
    logic [2:0]  e_io = 3'd0;
    logic [15:0] e_ad = 16'd0;
    logic [7:0]  e_wd = 8'd0;
    logic [7:0]  rv;
    string       tg = tag_of(op);

    @(negedge clk);
    chk(done == 1'b0, "R12", "done idle", {39'd0, done}, 40'd0);
    op_valid = 1'b1;
    op_code  = op;
    io_in    = iob;

    case (op[7:4])
      4'h0: if (n != 0) begin e_rd = 1; e_ad = m_r[n]; end
      4'h4: begin e_rd = 1; e_ad = m_r[n]; end
      4'h5: begin e_wr = 1; e_ad = m_r[n]; e_wd = m_d; end
      4'h6: begin
        if (n != 0 && n < 8) begin e_rd = 1; e_ad = m_r[m_x]; e_io = n[2:0]; end
        else if (n > 8) begin e_wr = 1; e_ad = m_r[m_x]; e_wd = iob; e_io = n[2:0]; end
      end
      4'h7: begin
        if (n == 2) begin e_rd = 1; e_ad = m_r[m_x]; end
        if (n == 3) begin e_wr = 1; e_ad = m_r[m_x]; e_wd = m_d; end
      end
      4'hF: if (n == 0) begin e_rd = 1; e_ad = m_r[m_x]; end
      default: ;
    endcase
    rv = mem[e_ad[7:0]];

    #(PERIOD/4);
    chk({mem_rd, mem_wr, io_sel} == {e_rd, e_wr, e_io}, tg, "strobes",
        {35'd0, mem_rd, mem_wr, io_sel}, {35'd0, e_rd, e_wr, e_io});
    if (e_rd || e_wr)
      chk(mem_addr == e_ad && (!e_wr || mem_wdata == e_wd), tg, "addr/wdata",
          {16'd0, mem_addr, mem_wdata}, {16'd0, e_ad, e_wd});
    if (e_wr) mem[e_ad[7:0]] = e_wd;

    case (op[7:4])
      4'h0: if (n != 0) m_d = rv;
      4'h1: m_r[n] = m_r[n] + 16'd1;
      4'h2: m_r[n] = m_r[n] - 16'd1;
      4'h4: begin m_d = rv; m_r[n] = m_r[n] + 16'd1; end
      4'h6: begin
        if (n < 8) m_r[m_x] = m_r[m_x] + 16'd1;
        else if (n > 8) m_d = iob;
      end
      4'h7: begin
        if (n == 2) begin m_d = rv; m_r[m_x] = m_r[m_x] + 16'd1; end
        if (n == 3) m_r[m_x] = m_r[m_x] - 16'd1;
      end
      4'h8: m_d = m_r[n][7:0];
      4'h9: m_d = m_r[n][15:8];
      4'hA: m_r[n][7:0]  = m_d;
      4'hB: m_r[n][15:8] = m_d;
      4'hD: m_p = n;
      4'hE: m_x = n;
      4'hF: if (n == 0) m_d = rv;
      default: ;
    endcase

    @(negedge clk);
    op_valid = 1'b0;
    chk(done == 1'b1, "R12", "done pulse", {39'd0, done}, 40'd1);
    chk({d_out, p_sel, x_sel} == {m_d, m_p, m_x}, tg, "D/P/X",
        {24'd0, d_out, p_sel, x_sel}, {24'd0, m_d, m_p, m_x});
  endtask

  task automatic dump_regs;
    for (int i = 0; i < 16; i++) begin
      do_op(8'h80 | 8'(i), 8'h00);
      do_op(8'h90 | 8'(i), 8'h00);
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    for (int i = 0; i < 16; i++) m_r[i] = 16'd0;
    m_d = 8'd0; m_p = 4'd0; m_x = 4'd0;
    op_valid = 1'b0; op_code = 8'd0; io_in = 8'd0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({done, mem_rd, mem_wr, io_sel, d_out, p_sel, x_sel} == '0, "R1",
        "state in reset", {16'd0, done, mem_rd, mem_wr, io_sel, d_out, p_sel, x_sel}, 40'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({done, d_out, p_sel, x_sel} == '0, "R1", "state after reset",
        {23'd0, done, d_out, p_sel, x_sel}, 40'd0);
    dump_regs();

    // R2 wrap corners: build FFFF in R5 from a memory byte of FF
    mem[0] = 8'hFF;
    do_op(8'h01, 8'h00);
    do_op(8'hB5, 8'h00);
    do_op(8'hA5, 8'h00);
    do_op(8'h15, 8'h00);
    do_op(8'h95, 8'h00);
    do_op(8'h85, 8'h00);
    do_op(8'h25, 8'h00);
    do_op(8'h95, 8'h00);
    // R3 idle opcode, R10 / R11 corner codes, R7 data pointer
    do_op(8'h00, 8'h00);
    do_op(8'hE5, 8'h00);
    do_op(8'h60, 8'h00);
    do_op(8'h68, 8'h5A);
    do_op(8'h61, 8'h00);
    do_op(8'h6F, 8'hC3);
    do_op(8'h73, 8'h00);
    do_op(8'h72, 8'h00);
    do_op(8'hF0, 8'h00);
    do_op(8'hD9, 8'h00);
    do_op(8'h3A, 8'h00);
    dump_regs();

    for (int k = 0; k < 3000; k++) do_op(8'($urandom), 8'($urandom));
    dump_regs();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule